// File: doc/BRIEF.md
# Two-Channel Register-Started Stream DMA

This block moves words between a flat memory and a pair of AXI4-Stream links. It has two independent channels. The read channel fetches a programmed run of 32-bit words from memory and sends them out as a stream master. The write channel accepts a stream and stores the words into memory at ascending addresses. Software drives each channel through a small word-addressed register bank. The bank holds a control register, a status register, an address register and a byte-length register for each channel.

To use a channel, software sets its run bit and loads the address. It then writes the length, and that write starts the transfer. Software polls the sticky completion flag to see when the transfer is over and clears the flag by writing 1 to it. Each channel also has a self-clearing soft reset, which returns the channel to its halted, idle state. The memory side is a plain single-cycle port: a combinational read port serves the read channel and a write port serves the write channel.

Top module: `stream_dma`

## Requirements
- R1: Registers are decoded by byte offset. Read channel: control 0x00, status 0x04, source address 0x18, length 0x28. Write channel: control 0x30, status 0x34, destination address 0x48, length 0x58. A read returns the addressed register combinationally in the same cycle, and unmapped offsets read as 0.
- R2: Status bit 0 is the halted flag. It reads 1 after reset and 0 while control bit 0 (run) is set. Control reads back with run in bit 0.
- R3: Writing a control value with bit 2 set starts a soft reset of that channel. In the cycle after the write, control bit 2 reads 1. One cycle later it reads 0, and by then run, completion flag, address and length of that channel all read 0, so status reads 0x1.
- R4: A length write starts a transfer only when the channel is running, idle and the length is at least 4. The started length reads back from the length register. A length write to a stopped channel or to a busy channel is ignored: nothing moves and the length register keeps its value.
- R5: The read channel sends length/4 words in order, taken from the source address upward in steps of 4 bytes.
- R6: The read channel raises TLAST on the final word of the transfer and on no other word. It drives TKEEP as 4'b1111 on every beat.
- R7: While TVALID is high and TREADY is low, the read channel keeps TVALID, TDATA and TLAST unchanged.
- R8: The write channel keeps TREADY low unless a transfer is in progress with a nonzero remaining length. Accepted word k is written to destination address + 4·k.
- R9: The write channel ends its transfer when the length is used up or when a beat with TLAST is accepted, whichever comes first. After that TREADY is low, and memory beyond the last accepted word is left untouched.
- R10: Status bit 12 is set when a transfer finishes and stays set until software writes 1 to status bit 12. If a finish and a clear happen in the same cycle, the finish wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Memory read data, same cycle |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| m_tdata | output | 32 | Read-channel stream data |
| m_tvalid | output | 1 | Read-channel stream valid |
| m_tready | input | 1 | Read-channel stream ready |
| m_tlast | output | 1 | Read-channel final beat |
| m_tkeep | output | 4 | Read-channel byte keep |
| s_tdata | input | 32 | Write-channel stream data |
| s_tvalid | input | 1 | Write-channel stream valid |
| s_tready | output | 1 | Write-channel stream ready |
| s_tlast | input | 1 | Write-channel final beat |

## Verification
The assertions assume that the memory read data depends only on the read address within a cycle, so a held address yields held data. They also assume that length values are multiples of 4 and that addresses are word aligned. The stimulus satisfies both. The bench memory model is a plain combinational array. Every programmed length and address is built as a word count times 4, and the stream source only changes TDATA and TLAST while TVALID is low or after a beat has been accepted.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 32;
    localparam int LEN_W     = 16;
    localparam int REG_AW    = 8;
    localparam int NUM_CH    = 2;
    localparam int CH_STRIDE = 'h30;
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_STAT  = 'h04;
    localparam int OFF_ADDR  = 'h18;
    localparam int OFF_LEN   = 'h28;
    localparam int BIT_RUN   = 0;
    localparam int BIT_SRST  = 2;
    localparam int BIT_HALT  = 0;
    localparam int BIT_DONE  = 12;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BYTE_SH    = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {RD_IDLE, RD_FETCH, RD_SEND} rd_state_e;

    typedef struct packed {
        logic run;
        logic srst_pend;
        logic done;
    } chan_flags_t;

    function automatic logic [REG_AW-1:0] reg_off(int ch, int off);
        return REG_AW'(ch * CH_STRIDE + off);
    endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_pkg::*;
#(
    parameter int CH = 0,
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W,
    parameter int RW = REG_AW,
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [RW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 busy,
    input  logic                 done_evt,
    output logic                 start,
    output logic [AW-1:0]        base,
    output logic [LW-BYTE_SH-1:0] nwords,
    output logic                 ch_rst
);
    localparam logic [RW-1:0] A_CTRL = reg_off(CH, OFF_CTRL);
    localparam logic [RW-1:0] A_STAT = reg_off(CH, OFF_STAT);
    localparam logic [RW-1:0] A_ADDR = reg_off(CH, OFF_ADDR);
    localparam logic [RW-1:0] A_LEN  = reg_off(CH, OFF_LEN);

    chan_flags_t   fl_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] len_q;
    logic wr_ctrl, wr_stat, wr_addr, wr_len;

    assign wr_ctrl = we && addr == A_CTRL && !fl_q.srst_pend;
    assign wr_stat = we && addr == A_STAT && !fl_q.srst_pend;
    assign wr_addr = we && addr == A_ADDR && !fl_q.srst_pend;
    assign wr_len  = we && addr == A_LEN  && !fl_q.srst_pend;

    assign nwords = wdata[LW-1:BYTE_SH];
    assign start  = wr_len && fl_q.run && !busy && (nwords != '0);
    assign base   = addr_q;
    assign ch_rst = fl_q.srst_pend;

    always_ff @(posedge clk) begin
        if (rst || fl_q.srst_pend) begin
            fl_q   <= '0;
            addr_q <= '0;
            len_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                if (wdata[BIT_SRST]) fl_q.srst_pend <= 1'b1;
                else                 fl_q.run       <= wdata[BIT_RUN];
            end
            if (wr_stat && wdata[BIT_DONE]) fl_q.done <= 1'b0;
            if (done_evt)                   fl_q.done <= 1'b1;
            if (wr_addr) addr_q <= wdata[AW-1:0];
            if (start)   len_q  <= wdata[LW-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[BIT_RUN]  = fl_q.run;
            rdata[BIT_SRST] = fl_q.srst_pend;
        end else if (addr == A_STAT) begin
            rdata[BIT_HALT] = !fl_q.run;
            rdata[BIT_DONE] = fl_q.done;
        end else if (addr == A_ADDR) begin
            rdata[AW-1:0] = addr_q;
        end else if (addr == A_LEN) begin
            rdata[LW-1:0] = len_q;
        end
    end

    // R3: the soft reset lasts one cycle and leaves the channel stopped
    assert_srst_selfclear_R3: assert property (@(posedge clk) disable iff (rst)
        fl_q.srst_pend |=> !fl_q.srst_pend && !fl_q.run && !fl_q.done);
    // R4: an accepted length write makes the engine busy
    assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    // R10: a finishing transfer always leaves the flag set
    assert_done_set_R10: assert property (@(posedge clk) disable iff (rst)
        done_evt && !fl_q.srst_pend |=> fl_q.done);
endmodule

// File: rtl/dma_mm2s.sv
module dma_mm2s
    import dma_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NW = LEN_W - BYTE_SH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   src,
    input  logic [NW-1:0]   nwords,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    input  logic [DW-1:0]   rd_data,
    output logic [DW-1:0]   tdata,
    output logic            tvalid,
    input  logic            tready,
    output logic            tlast,
    output logic [DW/8-1:0] tkeep,
    output logic            busy,
    output logic            done_evt
);
    rd_state_e    st_q;
    logic [AW-1:0] cur_q;
    logic [NW-1:0] cnt_q;
    logic [DW-1:0] dat_q;
    logic hs, last;

    assign hs       = (st_q == RD_SEND) && tready;
    assign last     = (cnt_q == NW'(1));
    assign rd_en    = (st_q == RD_FETCH) || (hs && !last);
    assign rd_addr  = cur_q;
    assign tvalid   = (st_q == RD_SEND);
    assign tdata    = dat_q;
    assign tlast    = tvalid && last;
    assign tkeep    = '1;
    assign busy     = (st_q != RD_IDLE);
    assign done_evt = hs && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RD_IDLE;
            cur_q <= '0;
            cnt_q <= '0;
            dat_q <= '0;
        end else begin
            unique case (st_q)
                RD_IDLE: if (start) begin
                    cur_q <= src;
                    cnt_q <= nwords;
                    st_q  <= RD_FETCH;
                end
                RD_FETCH: begin
                    dat_q <= rd_data;
                    cur_q <= cur_q + AW'(WORD_BYTES);
                    st_q  <= RD_SEND;
                end
                RD_SEND: if (tready) begin
                    if (last) begin
                        st_q <= RD_IDLE;
                    end else begin
                        dat_q <= rd_data;
                        cur_q <= cur_q + AW'(WORD_BYTES);
                        cnt_q <= cnt_q - NW'(1);
                    end
                end
                default: st_q <= RD_IDLE;
            endcase
        end
    end

    // R7: a stalled beat is held unchanged
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
        tvalid && !tready |=> tvalid && $stable(tdata) && $stable(tlast));
    // R6: nothing follows an accepted final beat
    assert_last_ends_R6: assert property (@(posedge clk) disable iff (rst)
        tlast && tready |=> !tvalid);
    // R5: memory is read only on behalf of a transfer
    assert_read_in_xfer_R5: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> tvalid);
endmodule

// File: rtl/dma_s2mm.sv
module dma_s2mm
    import dma_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NW = LEN_W - BYTE_SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] dst,
    input  logic [NW-1:0] nwords,
    input  logic [DW-1:0] tdata,
    input  logic          tvalid,
    output logic          tready,
    input  logic          tlast,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          done_evt
);
    logic          busy_q;
    logic [AW-1:0] cur_q;
    logic [NW-1:0] rem_q;
    logic hs;

    assign tready   = busy_q;
    assign hs       = tvalid && busy_q;
    assign wr_en    = hs;
    assign wr_addr  = cur_q;
    assign wr_data  = tdata;
    assign busy     = busy_q;
    assign done_evt = hs && (rem_q == NW'(1) || tlast);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
            rem_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cur_q  <= dst;
                rem_q  <= nwords;
            end
        end else if (hs) begin
            cur_q <= cur_q + AW'(WORD_BYTES);
            rem_q <= rem_q - NW'(1);
            if (done_evt) busy_q <= 1'b0;
        end
    end

    // R8: ready only with words still owed
    assert_ready_has_room_R8: assert property (@(posedge clk) disable iff (rst)
        tready |-> rem_q != '0);
    // R9: ready drops right after the ending beat
    assert_stop_after_end_R9: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !tready);
endmodule

// File: rtl/stream_dma.sv
module stream_dma
    import dma_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int LW  = LEN_W,
    parameter int RAW = REG_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic [DW-1:0]   mem_rd_data,
    output logic            mem_wr_en,
    output logic [AW-1:0]   mem_wr_addr,
    output logic [DW-1:0]   mem_wr_data,
    output logic [DW-1:0]   m_tdata,
    output logic            m_tvalid,
    input  logic            m_tready,
    output logic            m_tlast,
    output logic [DW/8-1:0] m_tkeep,
    input  logic [DW-1:0]   s_tdata,
    input  logic            s_tvalid,
    output logic            s_tready,
    input  logic            s_tlast
);
    localparam int NW = LW - BYTE_SH;
    localparam int CH_RD = 0;
    localparam int CH_WR = 1;

    logic [NUM_CH-1:0] st, crst, bsy, dn;
    logic [AW-1:0]     base [NUM_CH];
    logic [NW-1:0]     nw   [NUM_CH];
    logic [DW-1:0]     rdv  [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_chan_regs #(.CH(g), .AW(AW), .LW(LW), .RW(RAW), .DW(DW)) u_regs (
            .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
            .wdata(reg_wdata), .rdata(rdv[g]), .busy(bsy[g]),
            .done_evt(dn[g]), .start(st[g]), .base(base[g]),
            .nwords(nw[g]), .ch_rst(crst[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) reg_rdata = reg_rdata | rdv[i];
    end

    dma_mm2s #(.AW(AW), .DW(DW), .NW(NW)) u_rd (
        .clk(clk), .rst(rst || crst[CH_RD]), .start(st[CH_RD]),
        .src(base[CH_RD]), .nwords(nw[CH_RD]),
        .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
        .tdata(m_tdata), .tvalid(m_tvalid), .tready(m_tready),
        .tlast(m_tlast), .tkeep(m_tkeep),
        .busy(bsy[CH_RD]), .done_evt(dn[CH_RD])
    );

    dma_s2mm #(.AW(AW), .DW(DW), .NW(NW)) u_wr (
        .clk(clk), .rst(rst || crst[CH_WR]), .start(st[CH_WR]),
        .dst(base[CH_WR]), .nwords(nw[CH_WR]),
        .tdata(s_tdata), .tvalid(s_tvalid), .tready(s_tready), .tlast(s_tlast),
        .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
        .busy(bsy[CH_WR]), .done_evt(dn[CH_WR])
    );

    // R6: every beat carries all bytes
    assert_keep_full_R6: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> $countones(m_tkeep) == DW/8);
endmodule

// File: tb/sim_stream_dma.sv
module sim_stream_dma;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] M_CTRL = 8'h00, M_STAT = 8'h04, M_SRC = 8'h18, M_LEN = 8'h28;
    localparam logic [7:0] S_CTRL = 8'h30, S_STAT = 8'h34, S_DST = 8'h48, S_LEN = 8'h58;

    logic clk = 0, rst = 1;
    logic reg_we = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_rd_en, mem_wr_en;
    logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
    logic [31:0] m_tdata, s_tdata = 0;
    logic m_tvalid, m_tready = 0, m_tlast, s_tvalid = 0, s_tready, s_tlast = 0;
    logic [3:0] m_tkeep;

    int n_chk = 0, n_fail = 0;
    int rdy_mode = 0;
    logic [31:0] mem [256];
    logic [31:0] cap [64];
    logic        cap_last [64];
    int ncap = 0;
    logic [31:0] sx [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_dma u0 (.*);

    assign mem_rd_data = mem[mem_rd_addr[9:2]];
    always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr[9:2]] <= mem_wr_data;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0: m_tready = 1;
                1: m_tready = ($urandom % 3) != 0;
                default: m_tready = 0;
            endcase
        end
    end

    logic was_stall = 0;
    logic [31:0] st_data;
    logic st_last;
    always @(negedge clk) begin
        if (!rst) begin
            if (was_stall) begin
                chk("R7 valid held", {31'b0, m_tvalid}, 32'h1);
                chk("R7 data held", m_tdata, st_data);
                chk("R7 last held", {31'b0, m_tlast}, {31'b0, st_last});
            end
            was_stall = m_tvalid && !m_tready;
            st_data = m_tdata;
            st_last = m_tlast;
            if (m_tvalid && m_tready) begin
                if (m_tkeep !== 4'hF) chk("R6 tkeep", {28'b0, m_tkeep}, 32'hF);
                if (ncap < 64) begin
                    cap[ncap] = m_tdata;
                    cap_last[ncap] = m_tlast;
                end
                ncap++;
            end
        end
    end

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(logic [7:0] stat);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_read(stat, v);
            if (v[12]) break;
        end
    endtask

    task automatic run_mm2s(logic [31:0] src, int nw, int mode);
        logic [31:0] v;
        rdy_mode = mode;
        ncap = 0;
        reg_write(M_SRC, src);
        reg_write(M_LEN, nw * 4);
        wait_done(M_STAT);
        repeat (2) @(negedge clk);
        reg_read(M_STAT, v);
        chk("R10 done set", {31'b0, v[12]}, 32'h1);
        chk("R5 beat count", ncap, nw);
        for (int i = 0; i < nw; i++) begin
            chk("R5 word", cap[i], mem[src[9:2] + i]);
            chk("R6 tlast", {31'b0, cap_last[i]}, {31'b0, i == nw - 1});
        end
        reg_write(M_STAT, 32'h1000);
        reg_read(M_STAT, v);
        chk("R10 w1c", v, 32'h0);
        rdy_mode = 0;
    endtask

    task automatic send_words(int n, int last_idx);
        for (int i = 0; i < n; i++) begin
            logic acc = 0;
            sx[i] = $urandom;
            while (!acc) begin
                @(negedge clk);
                if ($urandom % 4 == 0) begin
                    s_tvalid = 0;
                end else begin
                    s_tvalid = 1;
                    s_tdata  = sx[i];
                    s_tlast  = (i == last_idx);
                    acc = s_tready;
                end
            end
        end
        @(negedge clk);
        s_tvalid = 0;
        s_tlast  = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // reset state
        reg_read(M_STAT, v); chk("R2 rd halted at reset", v, 32'h1);
        reg_read(S_STAT, v); chk("R2 wr halted at reset", v, 32'h1);
        reg_read(8'h08, v);  chk("R1 unmapped reads 0", v, 32'h0);
        chk("R8 s_tready low at reset", {31'b0, s_tready}, 32'h0);

        // length write on a stopped channel is ignored
        reg_write(M_LEN, 32);
        repeat (5) @(negedge clk);
        chk("R4 no beat when stopped", {31'b0, m_tvalid}, 32'h0);
        reg_read(M_LEN, v); chk("R4 len kept when stopped", v, 32'h0);

        reg_write(M_CTRL, 1);
        reg_read(M_CTRL, v); chk("R2 run reads back", v, 32'h1);
        reg_read(M_STAT, v); chk("R2 halted clears", v, 32'h0);
        reg_write(M_SRC, 32'h40);
        reg_read(M_SRC, v); chk("R1 source address", v, 32'h40);

        run_mm2s(32'h40, 8, 0);
        run_mm2s(32'h80, 8, 1);
        run_mm2s(32'h3FC, 1, 1);

        // length write while busy is ignored
        rdy_mode = 2;
        ncap = 0;
        reg_write(M_SRC, 32'h100);
        reg_write(M_LEN, 16);
        repeat (3) @(negedge clk);
        reg_write(M_LEN, 32);
        reg_read(M_LEN, v); chk("R4 len kept when busy", v, 32'h10);
        rdy_mode = 0;
        wait_done(M_STAT);
        repeat (2) @(negedge clk);
        chk("R4 busy write no extra beats", ncap, 4);
        reg_write(M_STAT, 32'h1000);

        for (int k = 0; k < 4; k++) begin
            int nw = 1 + ($urandom % 8);
            logic [31:0] src = 32'(($urandom % 240) * 4);
            run_mm2s(src, nw, 1);
        end

        // soft reset of the read channel
        reg_write(M_STAT, 32'h1000);
        reg_write(M_CTRL, 32'h4);
        reg_read(M_CTRL, v); chk("R3 srst reads 1", v[2], 1'b1);
        @(negedge clk);
        reg_read(M_CTRL, v); chk("R3 srst self clears", v, 32'h0);
        reg_read(M_STAT, v); chk("R3 halted after srst", v, 32'h1);
        reg_read(M_SRC, v);  chk("R3 addr cleared", v, 32'h0);
        reg_read(M_LEN, v);  chk("R3 len cleared", v, 32'h0);

        // stream to memory, length used up
        reg_write(S_CTRL, 1);
        reg_write(S_DST, 32'h200);
        chk("R8 ready low before start", {31'b0, s_tready}, 32'h0);
        reg_write(S_LEN, 32);
        reg_read(S_DST, v); chk("R1 destination address", v, 32'h200);
        reg_read(S_LEN, v); chk("R1 write length", v, 32'h20);
        send_words(8, -1);
        @(negedge clk);
        for (int i = 0; i < 8; i++) chk("R8 stored word", mem[128 + i], sx[i]);
        chk("R9 ready low after length", {31'b0, s_tready}, 32'h0);
        reg_read(S_STAT, v); chk("R10 wr done", v, 32'h1000);
        reg_write(S_STAT, 32'h1000);

        // early TLAST
        for (int i = 0; i < 8; i++) mem[192 + i] = 32'hDEAD0000 + 32'(i);
        reg_write(S_DST, 32'h300);
        reg_write(S_LEN, 32);
        send_words(5, 4);
        @(negedge clk);
        for (int i = 0; i < 5; i++) chk("R9 early words", mem[192 + i], sx[i]);
        chk("R9 word after tlast untouched", mem[197], 32'hDEAD0005);
        chk("R9 ready low after tlast", {31'b0, s_tready}, 32'h0);
        reg_read(S_STAT, v); chk("R10 wr done early", v, 32'h1000);
        reg_write(S_STAT, 32'h1000);

        // short length with a longer stream available
        reg_write(S_DST, 32'h380);
        reg_write(S_LEN, 8);
        send_words(2, -1);
        s_tvalid = 1; s_tdata = 32'hBAD0BAD0;
        repeat (3) @(negedge clk);
        chk("R9 ready stays low", {31'b0, s_tready}, 32'h0);
        s_tvalid = 0;
        chk("R8 short stored 0", mem[224], sx[0]);
        chk("R8 short stored 1", mem[225], sx[1]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule